// File: doc/BRIEF.md
# Prescaled Reference-Compare Timer

A 16-bit up-counter with a small register window on a simple synchronous write bus and a combinational read port. The counter advances on ticks taken from the system clock, either directly or after a fixed divide-by-16 stage, and then through a programmable prescaler that divides by 1 to 256. Each time the count sits at the programmed reference value when a tick arrives, a sticky event flag is latched and, if selected, the count restarts from zero.

Software sets the mode, reference and count, clears the event flag by writing a one to it, and can reset the whole timer by dropping the run bit of the mode register. An interrupt line follows the event flag whenever the interrupt enable is set.

Register map (byte offsets in the window): mode 0x00, reference 0x04, counter 0x08, event 0x0C. Any other offset reads as zero and ignores writes. Mode fields: bit 0 run (0 holds the timer in reset), bits 2:1 clock source (0 stopped, 1 system clock, 2 system clock / 16, 3 stopped), bit 3 restart on reference, bit 4 interrupt enable, bits 15:8 prescale value P (divide by P+1). Event register bit 0 is the reference flag.

Top module: `ref_timer`

## Requirements
- R1: After rst_ni the mode reads 0x0000, the reference 0xFFFF, the counter 0x0000, the event register 0x0000, and irq_o is 0.
- R2: While mode bit 0 is 0 the counter does not count, whatever the clock source field holds.
- R3: With mode bit 0 set and the source field 0 or 3, the counter does not count.
- R4: With source 1 and prescale value P, the counter advances by one every P+1 clock cycles, the first step P+1 cycles after the mode write.
- R5: With source 2 and prescale value P, the counter advances by one every 16*(P+1) clock cycles, the first step 16*(P+1) cycles after the mode write.
- R6: With mode bit 3 set, a tick that finds the counter equal to the reference sets the counter to 0 and sets event bit 0.
- R7: With mode bit 3 clear, a tick that finds the counter equal to the reference sets event bit 0 and the counter keeps counting past it, wrapping from 0xFFFF to 0x0000.
- R8: Writing event bit 0 as 1 clears the flag; writing it as 0 leaves the flag unchanged.
- R9: irq_o is 1 exactly when mode bit 4 and event bit 0 are both 1.
- R10: A write to the counter loads the written value on that clock edge, taking priority over a tick in the same cycle.
- R11: A mode write that changes bit 0 from 1 to 0 returns reference, counter, event flag and prescaler to their reset values; the mode register takes the written value.
- R12: Each register reads back at its offset, unmapped offsets read 0x0000, and writes to unmapped offsets change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_i | input | 1 | Register write strobe |
| addr_i | input | 5 | Byte offset in the register window |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data for addr_i, combinational |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench times the first counter steps after a mode write for divide ratios of 1, 5 and 32, so an off-by-one in the prescaler or a missing divide-by-16 stage gives a different count at the sample point. It runs restart through the reference and the non-restart path through the 0xFFFF wrap, where a design that matched on the wrong cycle or reset on a non-restart match would show a wrong count or a missing flag. It writes zero and one to the event flag, drops the run bit while counting to expect the soft reset, and loads the counter in the same cycle as a tick, which would lose the load if the tick had priority.

// File: rtl/ref_timer_pkg.sv
package ref_timer_pkg;
  localparam int OFF_MODE = 0;
  localparam int OFF_REF  = 4;
  localparam int OFF_CNT  = 8;
  localparam int OFF_EVT  = 12;

  localparam int MB_RUN     = 0;
  localparam int MB_SRC     = 1;
  localparam int MB_RESTART = 3;
  localparam int MB_IE      = 4;
  localparam int MB_PRE     = 8;

  typedef enum logic [1:0] {
    SRC_STOP = 2'd0,
    SRC_SYS  = 2'd1,
    SRC_SLOW = 2'd2,
    SRC_RSVD = 2'd3
  } src_e;
endpackage

// File: rtl/rt_regs.sv
module rt_regs
  import ref_timer_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [DATA_W-1:0] cnt_i,
  input  logic              evt_i,
  output logic [DATA_W-1:0] mode_o,
  output logic [DATA_W-1:0] ref_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              mode_wr_o,
  output logic              cnt_wr_o,
  output logic              evt_clr_o,
  output logic              soft_rst_o
);
  logic sel_mode, sel_ref, sel_cnt, sel_evt;

  assign sel_mode = addr_i == ADDR_W'(OFF_MODE);
  assign sel_ref  = addr_i == ADDR_W'(OFF_REF);
  assign sel_cnt  = addr_i == ADDR_W'(OFF_CNT);
  assign sel_evt  = addr_i == ADDR_W'(OFF_EVT);

  assign mode_wr_o  = wr_i && sel_mode;
  assign cnt_wr_o   = wr_i && sel_cnt;
  assign evt_clr_o  = wr_i && sel_evt && wdata_i[0];
  // run bit falling under software control
  assign soft_rst_o = mode_wr_o && mode_o[MB_RUN] && !wdata_i[MB_RUN];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_o <= '0;
      ref_o  <= '1;
    end else begin
      if (mode_wr_o) mode_o <= wdata_i;
      if (soft_rst_o) ref_o <= '1;
      else if (wr_i && sel_ref) ref_o <= wdata_i;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (sel_mode) rdata_o = mode_o;
    if (sel_ref)  rdata_o = ref_o;
    if (sel_cnt)  rdata_o = cnt_i;
    if (sel_evt)  rdata_o = {{(DATA_W-1){1'b0}}, evt_i};
  end
endmodule

// File: rtl/rt_prescaler.sv
module rt_prescaler
  import ref_timer_pkg::*;
#(
  parameter int PRE_W     = 8,
  parameter int SLOW_LOG2 = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  src_e             src_i,
  input  logic [PRE_W-1:0] pre_i,
  input  logic             clr_i,
  output logic             tick_o
);
  logic             active, slow_pulse, src_pulse;
  logic [PRE_W-1:0] pre_q;

  assign active = run_i && (src_i == SRC_SYS || src_i == SRC_SLOW);

  generate
    if (SLOW_LOG2 > 0) begin : g_slow
      logic [SLOW_LOG2-1:0] div_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) div_q <= '0;
        else if (!active || clr_i) div_q <= '0;
        else div_q <= div_q + 1'b1;
      end
      assign slow_pulse = &div_q;
    end else begin : g_noslow
      assign slow_pulse = 1'b1;
    end
  endgenerate

  assign src_pulse = (src_i == SRC_SLOW) ? slow_pulse : 1'b1;
  assign tick_o    = active && src_pulse && (pre_q == pre_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pre_q <= '0;
    else if (!active || clr_i) pre_q <= '0;
    else if (src_pulse) pre_q <= (pre_q == pre_i) ? '0 : pre_q + 1'b1;
  end
endmodule

// File: rtl/rt_counter.sv
module rt_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] ref_i,
  input  logic             restart_i,
  input  logic             soft_rst_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             evt_clr_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             evt_o
);
  logic match;
  assign match = cnt_o == ref_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_o <= '0;
      evt_o <= 1'b0;
    end else begin
      if (soft_rst_i) cnt_o <= '0;
      else if (load_i) cnt_o <= load_val_i;
      else if (tick_i) cnt_o <= (match && restart_i) ? '0 : cnt_o + 1'b1;

      // a new match wins over a clear in the same cycle
      if (soft_rst_i) evt_o <= 1'b0;
      else if (tick_i && match) evt_o <= 1'b1;
      else if (evt_clr_i) evt_o <= 1'b0;
    end
  end
endmodule

// File: rtl/ref_timer.sv
module ref_timer
  import ref_timer_pkg::*;
#(
  parameter int CNT_W     = 16,
  parameter int PRE_W     = 8,
  parameter int SLOW_LOG2 = 4,
  parameter int ADDR_W    = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [CNT_W-1:0]  wdata_i,
  output logic [CNT_W-1:0]  rdata_o,
  output logic              irq_o
);
  logic [CNT_W-1:0] mode_q, ref_q, cnt_q;
  logic             evt_q, tick;
  logic             mode_wr, cnt_wr, evt_clr, soft_rst;
  src_e             src;

  assign src = src_e'(mode_q[MB_SRC +: 2]);

  rt_regs #(.DATA_W(CNT_W), .ADDR_W(ADDR_W)) i_regs (
    .clk_i, .rst_ni, .wr_i, .addr_i, .wdata_i,
    .cnt_i(cnt_q), .evt_i(evt_q),
    .mode_o(mode_q), .ref_o(ref_q), .rdata_o,
    .mode_wr_o(mode_wr), .cnt_wr_o(cnt_wr), .evt_clr_o(evt_clr), .soft_rst_o(soft_rst)
  );

  rt_prescaler #(.PRE_W(PRE_W), .SLOW_LOG2(SLOW_LOG2)) i_pre (
    .clk_i, .rst_ni,
    .run_i(mode_q[MB_RUN]), .src_i(src), .pre_i(mode_q[MB_PRE +: PRE_W]),
    .clr_i(mode_wr), .tick_o(tick)
  );

  rt_counter #(.CNT_W(CNT_W)) i_cnt (
    .clk_i, .rst_ni, .tick_i(tick), .ref_i(ref_q),
    .restart_i(mode_q[MB_RESTART]), .soft_rst_i(soft_rst),
    .load_i(cnt_wr), .load_val_i(wdata_i), .evt_clr_i(evt_clr),
    .cnt_o(cnt_q), .evt_o(evt_q)
  );

  assign irq_o = mode_q[MB_IE] && evt_q;
endmodule

// File: rtl/rt_checker.sv
module rt_checker
  import ref_timer_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 5
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [CNT_W-1:0]  wdata_i,
  input logic [CNT_W-1:0]  mode_i,
  input logic [CNT_W-1:0]  ref_i,
  input logic [CNT_W-1:0]  cnt_i,
  input logic              evt_i,
  input logic              tick_i
);
  logic mode_wr, cnt_wr, evt_wr1, falling;
  assign mode_wr = wr_i && addr_i == ADDR_W'(OFF_MODE);
  assign cnt_wr  = wr_i && addr_i == ADDR_W'(OFF_CNT);
  assign evt_wr1 = wr_i && addr_i == ADDR_W'(OFF_EVT) && wdata_i[0];
  assign falling = mode_wr && mode_i[MB_RUN] && !wdata_i[MB_RUN];

  p_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mode_i[MB_RUN] && !cnt_wr |=> $stable(cnt_i));

  p_stop_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_i[MB_RUN] && (mode_i[MB_SRC +: 2] == 2'd0 || mode_i[MB_SRC +: 2] == 2'd3)
    && !mode_wr && !cnt_wr |=> $stable(cnt_i));

  p_step_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i && !cnt_wr && !falling && !(cnt_i == ref_i && mode_i[MB_RESTART])
    |=> cnt_i == $past(cnt_i) + CNT_W'(1));

  p_restart_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i && cnt_i == ref_i && mode_i[MB_RESTART] && !cnt_wr && !falling
    |=> cnt_i == '0 && evt_i);

  p_match_flag_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i && cnt_i == ref_i && !falling |=> evt_i);

  p_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_i && !evt_wr1 && !falling |=> evt_i);

  p_load_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_wr |=> cnt_i == $past(wdata_i));

  p_soft_rst_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    falling |=> cnt_i == '0 && ref_i == '1 && !evt_i);
endmodule

bind ref_timer rt_checker #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .wr_i(wr_i), .addr_i(addr_i), .wdata_i(wdata_i),
  .mode_i(mode_q), .ref_i(ref_q), .cnt_i(cnt_q), .evt_i(evt_q), .tick_i(tick)
);

// File: tb/test_ref_timer.sv
module test_ref_timer;
  localparam int CLK_PERIOD = 10;
  localparam logic [4:0] A_MODE = 5'h00, A_REF = 5'h04, A_CNT = 5'h08, A_EVT = 5'h0C;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_i = 1'b0;
  logic [4:0]  addr_i = '0;
  logic [15:0] wdata_i = '0;
  logic [15:0] rdata_o;
  logic        irq_o;

  typedef struct {
    string       tag;
    bit          is_irq;
    logic [15:0] exp;
  } item_t;

  item_t q[$];
  event  mon_ev;
  int    n_chk = 0;
  int    n_fail = 0;
  bit    done = 1'b0;

  ref_timer i_ref_timer (.*);

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  // monitor: pops the expected item and compares it with the port value
  always @(mon_ev) begin
    item_t it;
    logic [15:0] act;
    it = q.pop_front();
    act = it.is_irq ? {15'b0, irq_o} : rdata_o;
    n_chk++;
    if (act !== it.exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", it.tag, act, it.exp);
    end
  end

  task automatic wr(input logic [4:0] a, input logic [15:0] d);
    wr_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    wr_i = 1'b0;
  endtask

  task automatic push_chk(input string tag, input bit is_irq, input logic [15:0] e);
    item_t it;
    it.tag = tag; it.is_irq = is_irq; it.exp = e;
    q.push_back(it);
    #(CLK_PERIOD/4);
    -> mon_ev;
    @(negedge clk_i);
  endtask

  task automatic chk_reg(input logic [4:0] a, input logic [15:0] e, input string tag);
    addr_i = a;
    push_chk(tag, 1'b0, e);
  endtask

  task automatic chk_irq(input logic e, input string tag);
    push_chk(tag, 1'b1, {15'b0, e});
  endtask

  task automatic waitc(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic reinit();
    wr(A_MODE, 16'h0000);
    wr(A_REF, 16'hFFFF);
    wr(A_CNT, 16'h0000);
    wr(A_EVT, 16'h0001);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (50000) @(posedge clk_i);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog R1 actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    waitc(2);
    rst_ni = 1'b1;
    waitc(1);

    // R1 reset state
    chk_reg(A_MODE, 16'h0000, "R1 mode");
    chk_reg(A_REF,  16'hFFFF, "R1 ref");
    chk_reg(A_CNT,  16'h0000, "R1 cnt");
    chk_reg(A_EVT,  16'h0000, "R1 evt");
    chk_irq(1'b0, "R1 irq");
    chk_reg(5'h10, 16'h0000, "R12 unmapped read");

    // R4 divide by 1
    reinit();
    wr(A_MODE, 16'h0003);
    waitc(10);
    chk_reg(A_CNT, 16'd10, "R4 div1 count");

    // R4 divide by 5
    reinit();
    wr(A_MODE, 16'h0403);
    waitc(23);
    chk_reg(A_CNT, 16'd4, "R4 div5 count");
    chk_reg(A_MODE, 16'h0403, "R12 mode readback");

    // R5 slow source, P=1: divide by 32
    reinit();
    wr(A_MODE, 16'h0105);
    waitc(100);
    chk_reg(A_CNT, 16'd3, "R5 div32 count");

    // R2 held in reset by run bit, load still works (R10)
    reinit();
    wr(A_MODE, 16'h0002);
    waitc(20);
    chk_reg(A_CNT, 16'd0, "R2 no count");
    wr(A_CNT, 16'h0033);
    waitc(5);
    chk_reg(A_CNT, 16'h0033, "R2 hold after R10 load");

    // R3 stopped sources
    reinit();
    wr(A_MODE, 16'h0001);
    waitc(20);
    chk_reg(A_CNT, 16'd0, "R3 source 0");
    wr(A_MODE, 16'h0007);
    waitc(20);
    chk_reg(A_CNT, 16'd0, "R3 source 3");

    // R6 restart with ref 5
    reinit();
    wr(A_REF, 16'd5);
    wr(A_MODE, 16'h000B);
    waitc(8);
    chk_reg(A_CNT, 16'd2, "R6 restart count");
    chk_reg(A_EVT, 16'h0001, "R6 flag");
    chk_irq(1'b0, "R9 irq off without enable");
    wr(A_MODE, 16'h0011);
    chk_irq(1'b1, "R9 irq with enable and flag");
    wr(A_EVT, 16'h0000);
    chk_reg(A_EVT, 16'h0001, "R8 write zero keeps flag");
    wr(A_EVT, 16'h0001);
    chk_reg(A_EVT, 16'h0000, "R8 write one clears flag");
    chk_irq(1'b0, "R9 irq off after clear");

    // R7 no restart, wrap through 0xFFFF, ref 3
    reinit();
    wr(A_REF, 16'd3);
    wr(A_CNT, 16'hFFFD);
    wr(A_MODE, 16'h0003);
    waitc(5);
    chk_reg(A_EVT, 16'h0000, "R7 no flag before match");
    chk_reg(A_CNT, 16'd3, "R7 wrapped count");
    chk_reg(A_EVT, 16'h0001, "R7 flag on match");
    chk_reg(A_CNT, 16'd5, "R7 counts past ref");

    // R11 falling run bit resets timer
    wr(A_MODE, 16'h0A00);
    chk_reg(A_MODE, 16'h0A00, "R11 mode takes written value");
    chk_reg(A_REF, 16'hFFFF, "R11 ref reset");
    chk_reg(A_CNT, 16'h0000, "R11 cnt reset");
    chk_reg(A_EVT, 16'h0000, "R11 evt reset");

    // R10 load wins over tick
    reinit();
    wr(A_MODE, 16'h0003);
    waitc(3);
    wr(A_CNT, 16'h1000);
    chk_reg(A_CNT, 16'h1000, "R10 load over tick");
    chk_reg(A_CNT, 16'h1001, "R4 step after load");

    // R12 readback and ignored unmapped write
    wr(A_REF, 16'h1234);
    chk_reg(A_REF, 16'h1234, "R12 ref readback");
    wr(5'h14, 16'hFFFF);
    chk_reg(A_REF, 16'h1234, "R12 unmapped write ref");
    chk_reg(A_MODE, 16'h0003, "R12 unmapped write mode");

    done = 1'b1;
    summary();
    $finish;
  end
endmodule